// File: doc/BRIEF.md
# Multiply-Accumulate Product Stage

This block is the front half of a multiply-accumulate pipeline. It takes two 32-bit operands and turns them into the 64-bit value that the accumulator adds or subtracts. Control comes from a size select (16-bit half or full 32-bit operand), a half select per operand, a 2-bit scale field and four mode bits of the unit's status byte. The mode bits choose unsigned integer, signed integer or fractional arithmetic, enable round-half-even in fractional mode, and enable forced-overflow substitution.

For each accepted operand pair the block reports one result, one cycle later, with a flag telling whether this product overflowed the 40-bit integer range. In integer modes with substitution enabled, an overflowing product is replaced by a value of magnitude 2^50. Such a value is certain to push the downstream accumulator into its own overflow handling. The block neither stores the flag nor merges it anywhere, and it does not fetch operands or hold accumulators.

Top module: `mac_product_stage`

## Requirements
- R1: An operand pair presented with `inValid` high at a rising edge produces `outValid` high after that edge for exactly one cycle, carrying that pair's `product` and `prodOvf`. After an edge with `inValid` low, `outValid` is low and `product` and `prodOvf` keep their previous values, whatever the other inputs do.
- R2: While `rstN` is low, `outValid`, `product` and `prodOvf` are all zero.
- R3: With `isLong` = 1 each operand is used whole. With `isLong` = 0 each operand is cut to bits 31:16 when its upper select is 1, or bits 15:0 when it is 0. In fractional mode the half is placed in bits 31:16 with zeros below. In signed integer mode it is sign-extended, and in unsigned integer mode it is zero-extended.
- R4: Signed integer mode multiplies the operands as two's complement numbers, giving a 64-bit sign-extended result. `prodOvf` is 1 when the product lies outside [-2^39, 2^39-1]. When substitution is off, the product is passed on unchanged.
- R5: In signed integer mode, when substitution is on and `prodOvf` is 1, the product becomes 2^50 (0x0004_0000_0000_0000) if the true product is positive. It becomes the bitwise inverse of 2^50 (0xFFFB_FFFF_FFFF_FFFF) if the true product is negative.
- R6: Unsigned integer mode multiplies the operands as unsigned numbers. `prodOvf` is 1 when the product is 2^40 or larger. An overflowing product then becomes 2^50 when substitution is on, or is cut to its low 40 bits when it is off.
- R7: Fractional mode multiplies the operands as two's complement numbers and shifts the 64-bit product right by 24 bits, copying the sign into the vacated bits. `prodOvf` is always 0 in this mode.
- R8: In fractional mode with rounding on, the discarded 24 bits are compared with 0x800000. Above it, the result is incremented. Equal to it, the result's LSB is added, which rounds to even. Below it, the result is truncated. The rounding bit has no effect in integer modes.
- R9: In integer modes, scale value 1 shifts the final product (after substitution or truncation) left by one. Scale value 3 shifts it right by one: arithmetic in signed mode, logical in unsigned mode. Scale values 0 and 2 leave it unchanged. `prodOvf` is taken from the unscaled product. Fractional mode ignores the scale field.
- R10: The status byte bits are: substitution enable = bit 7, signed = bit 6, fractional = bit 5, rounding = bit 4. Fractional takes precedence over signed. Bits 3:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair and controls are valid this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| isLong | input | 1 | 1: use full operands; 0: use one 16-bit half of each |
| aUpper | input | 1 | Half select for opA: 1 upper, 0 lower |
| bUpper | input | 1 | Half select for opB: 1 upper, 0 lower |
| scale | input | 2 | Product scale field (integer modes) |
| macStatus | input | 8 | Status byte carrying the mode bits |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| product | output | 64 | Product prepared for accumulation |
| prodOvf | output | 1 | Overflow flag of this product |

## Verification
The bench builds the block with its default widths: 32-bit operands, a 40-bit integer range, 24 dropped fractional bits and a 2^50 substitution value. It also uses an 8-bit status byte. With these values every boundary can be reached with directed operands: products exactly at 2^40 and 2^39, the most negative operand squared, and discarded fractions just below, at and above the halfway point with both LSB parities. A long run of random operands, half selects, scale values and status bytes then covers all three modes, with the fractional/signed precedence and unrelated status bits mixed in.

// File: rtl/mac_fe_pkg.sv
package mac_fe_pkg;

  // Bit positions of the mode controls inside the status byte
  localparam int OMC_BIT = 7;
  localparam int SU_BIT  = 6;
  localparam int FI_BIT  = 5;
  localparam int RT_BIT  = 4;

  typedef enum logic [1:0] {
    MODE_UNS  = 2'd0,
    MODE_SGN  = 2'd1,
    MODE_FRAC = 2'd2
  } mac_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic longOp;
    logic aHi;
    logic bHi;
    logic fracMode;
    logic signedMode;
    logic roundEn;
    logic forceEn;
    logic scaleUp;
    logic scaleDown;
  } mac_fe_ctl_t;

endpackage

// File: rtl/mac_word_pick.sv
module mac_word_pick #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] opIn,
  input  logic            longOp,
  input  logic            hiSel,
  input  logic            fracMode,
  input  logic            signedMode,
  output logic [OP_W-1:0] opOut,
  output logic            extBit
);
  localparam int HALF_W = OP_W / 2;

  logic [HALF_W-1:0] half;

  assign half = hiSel ? opIn[OP_W-1:HALF_W] : opIn[HALF_W-1:0];

  always_comb begin
    if (longOp)
      opOut = opIn;
    else if (fracMode)
      opOut = {half, {HALF_W{1'b0}}};
    else if (signedMode)
      opOut = {{HALF_W{half[HALF_W-1]}}, half};
    else
      opOut = {{HALF_W{1'b0}}, half};
  end

  // Extension bit for the 33-bit shared multiplier
  assign extBit = (fracMode | signedMode) & opOut[OP_W-1];
endmodule

// File: rtl/mac_fe_ctrl.sv
module mac_fe_ctrl
  import mac_fe_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              isLong,
  input  logic              aUpper,
  input  logic              bUpper,
  input  logic [1:0]        scale,
  input  logic [STAT_W-1:0] macStatus,
  output mac_fe_ctl_t       ctl,
  output logic              outValid
);
  mac_mode_e mode;
  logic      unusedStatus;

  assign unusedStatus = ^macStatus[RT_BIT-1:0];

  always_comb begin
    if (macStatus[FI_BIT])
      mode = MODE_FRAC;
    else if (macStatus[SU_BIT])
      mode = MODE_SGN;
    else
      mode = MODE_UNS;
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = inValid;
    ctl.longOp     = isLong;
    ctl.aHi        = aUpper;
    ctl.bHi        = bUpper;
    ctl.fracMode   = (mode == MODE_FRAC);
    ctl.signedMode = (mode == MODE_SGN);
    ctl.roundEn    = (mode == MODE_FRAC) && macStatus[RT_BIT];
    ctl.forceEn    = (mode != MODE_FRAC) && macStatus[OMC_BIT];
    ctl.scaleUp    = (mode != MODE_FRAC) && (scale == 2'd1);
    ctl.scaleDown  = (mode != MODE_FRAC) && (scale == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/mac_fe_dpath.sv
module mac_fe_dpath
  import mac_fe_pkg::*;
#(
  parameter int OP_W      = 32,
  parameter int INT_W     = 40,
  parameter int FRAC_DROP = 24,
  parameter int FORCE_POS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_fe_ctl_t       ctl,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product,
  output logic              prodOvf
);
  localparam int PROD_W = 2 * OP_W;
  localparam int MUL_W  = 2 * (OP_W + 1);
  localparam logic [FRAC_DROP-1:0] HALFWAY = {1'b1, {(FRAC_DROP-1){1'b0}}};
  localparam logic [PROD_W-1:0] FORCE_VAL =
    {{(PROD_W-FORCE_POS-1){1'b0}}, 1'b1, {FORCE_POS{1'b0}}};

  logic [1:0][OP_W-1:0] rawOps;
  logic [1:0][OP_W-1:0] pickedOps;
  logic [1:0]           hiSel;
  logic [1:0]           extBits;

  assign rawOps[0] = opA;
  assign rawOps[1] = opB;
  assign hiSel     = {ctl.bHi, ctl.aHi};

  for (genvar i = 0; i < 2; i++) begin : g_pick
    mac_word_pick #(.OP_W(OP_W)) u_pick (
      .opIn      (rawOps[i]),
      .longOp    (ctl.longOp),
      .hiSel     (hiSel[i]),
      .fracMode  (ctl.fracMode),
      .signedMode(ctl.signedMode),
      .opOut     (pickedOps[i]),
      .extBit    (extBits[i])
    );
  end

  // One shared signed multiplier; the extension bit selects signedness
  logic signed [OP_W:0]  mulA, mulB;
  logic signed [MUL_W-1:0] mulFull;
  logic [PROD_W-1:0]     prod;
  logic [1:0]            unusedProdTop;

  assign mulA          = {extBits[0], pickedOps[0]};
  assign mulB          = {extBits[1], pickedOps[1]};
  assign mulFull       = mulA * mulB;
  assign prod          = mulFull[PROD_W-1:0];
  assign unusedProdTop = mulFull[MUL_W-1:PROD_W];

  // Fractional path
  logic [PROD_W-1:0]    fracShift, fracRes;
  logic [FRAC_DROP-1:0] fracRem;
  logic                 roundUp;

  assign fracShift = $signed(prod) >>> FRAC_DROP;
  assign fracRem   = prod[FRAC_DROP-1:0];
  assign roundUp   = ctl.roundEn &&
                     ((fracRem > HALFWAY) || ((fracRem == HALFWAY) && fracShift[0]));
  assign fracRes   = fracShift + {{(PROD_W-1){1'b0}}, roundUp};

  // Integer path: range check, substitution, scaling
  logic [PROD_W-INT_W:0] sgnTop;
  logic                  sgnOvf, unsOvf, intOvf;
  logic [PROD_W-1:0]     substRes, scaledRes;

  assign sgnTop = prod[PROD_W-1:INT_W-1];
  assign sgnOvf = !((&sgnTop) || !(|sgnTop));
  assign unsOvf = |prod[PROD_W-1:INT_W];
  assign intOvf = ctl.signedMode ? sgnOvf : unsOvf;

  always_comb begin
    substRes = prod;
    if (intOvf) begin
      if (ctl.forceEn)
        substRes = (ctl.signedMode && prod[PROD_W-1]) ? ~FORCE_VAL : FORCE_VAL;
      else if (!ctl.signedMode)
        substRes = {{(PROD_W-INT_W){1'b0}}, prod[INT_W-1:0]};
    end
  end

  always_comb begin
    if (ctl.scaleUp)
      scaledRes = {substRes[PROD_W-2:0], 1'b0};
    else if (ctl.scaleDown)
      scaledRes = {ctl.signedMode & substRes[PROD_W-1], substRes[PROD_W-1:1]};
    else
      scaledRes = substRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
      prodOvf <= 1'b0;
    end else if (ctl.load) begin
      product <= ctl.fracMode ? fracRes : scaledRes;
      prodOvf <= !ctl.fracMode && intOvf;
    end
  end
endmodule

// File: rtl/mac_product_stage.sv
module mac_product_stage
  import mac_fe_pkg::*;
#(
  parameter int OP_W      = 32,
  parameter int INT_W     = 40,
  parameter int FRAC_DROP = 24,
  parameter int FORCE_POS = 50,
  parameter int STAT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              isLong,
  input  logic              aUpper,
  input  logic              bUpper,
  input  logic [1:0]        scale,
  input  logic [STAT_W-1:0] macStatus,
  output logic              outValid,
  output logic [2*OP_W-1:0] product,
  output logic              prodOvf
);
  mac_fe_ctl_t ctl;

  mac_fe_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isLong   (isLong),
    .aUpper   (aUpper),
    .bUpper   (bUpper),
    .scale    (scale),
    .macStatus(macStatus),
    .ctl      (ctl),
    .outValid (outValid)
  );

  mac_fe_dpath #(
    .OP_W     (OP_W),
    .INT_W    (INT_W),
    .FRAC_DROP(FRAC_DROP),
    .FORCE_POS(FORCE_POS)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .product(product),
    .prodOvf(prodOvf)
  );
endmodule

// File: rtl/mac_product_stage_chk.sv
module mac_product_stage_chk
  import mac_fe_pkg::*;
#(
  parameter int OP_W      = 32,
  parameter int INT_W     = 40,
  parameter int FORCE_POS = 50,
  parameter int STAT_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        scale,
  input logic [STAT_W-1:0] macStatus,
  input logic              outValid,
  input logic [2*OP_W-1:0] product,
  input logic              prodOvf
);
  localparam int PROD_W = 2 * OP_W;
  localparam logic [PROD_W-1:0] FORCE_VAL =
    {{(PROD_W-FORCE_POS-1){1'b0}}, 1'b1, {FORCE_POS{1'b0}}};

  logic fi, su, omc;
  assign fi  = macStatus[FI_BIT];
  assign su  = macStatus[SU_BIT];
  assign omc = macStatus[OMC_BIT];

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (!outValid && product == '0 && !prodOvf); // R2
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(product) && $stable(prodOvf))); // R1

  AST_FRAC_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fi) |=> !prodOvf); // R7

  AST_UNS_TRUNC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fi && !su && !omc && scale != 2'd1) |=> (product[PROD_W-1:INT_W] == '0)); // R6

  AST_UNS_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fi && !su && omc && scale == 2'd0) |=> (prodOvf == (product == FORCE_VAL))); // R6

  AST_SGN_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fi && su && omc && scale == 2'd0 ) |=>
      (!prodOvf || product == FORCE_VAL || product == ~FORCE_VAL)); // R5
endmodule

bind mac_product_stage mac_product_stage_chk #(
  .OP_W     (OP_W),
  .INT_W    (INT_W),
  .FORCE_POS(FORCE_POS),
  .STAT_W   (STAT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .scale    (scale),
  .macStatus(macStatus),
  .outValid (outValid),
  .product  (product),
  .prodOvf  (prodOvf)
);

// File: tb/mac_product_stage_bench.sv
module mac_product_stage_bench;
  localparam logic [7:0] ST_OMC = 8'h80;
  localparam logic [7:0] ST_SU  = 8'h40;
  localparam logic [7:0] ST_FI  = 8'h20;
  localparam logic [7:0] ST_RT  = 8'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        isLong = 1'b0, aUpper = 1'b0, bUpper = 1'b0;
  logic [1:0]  scale = '0;
  logic [7:0]  macStatus = '0;
  logic        outValid;
  logic [63:0] product;
  logic        prodOvf;

  always #5 clk = ~clk;

  mac_product_stage u_mac_product_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .isLong(isLong), .aUpper(aUpper), .bUpper(bUpper), .scale(scale),
    .macStatus(macStatus), .outValid(outValid), .product(product), .prodOvf(prodOvf)
  );

  typedef struct {
    logic [63:0] p;
    logic        v;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          compared = 0;
  int          mismatched = 0;
  logic        sampledValid = 1'b0;
  logic [63:0] lastProd = '0;
  logic        lastOvf = 1'b0;
  bit          done = 0;

  function automatic logic [31:0] pick(logic [31:0] op, logic lng, logic hi, logic fi, logic su);
    logic [15:0] h;
    h = hi ? op[31:16] : op[15:0];
    if (lng) return op;
    if (fi)  return {h, 16'h0};
    if (su)  return {{16{h[15]}}, h};
    return {16'h0, h};
  endfunction

  function automatic logic [64:0] model(logic [31:0] a, logic [31:0] b, logic lng,
                                        logic ah, logic bh, logic [1:0] sc, logic [7:0] st);
    logic fi, su, omc, rt, v;
    logic [31:0] x, y;
    longint sa, sb, sp, q, lim;
    longint unsigned up;
    logic [23:0] rem;
    fi = st[5]; su = st[6]; omc = st[7]; rt = st[4];
    x = pick(a, lng, ah, fi, su);
    y = pick(b, lng, bh, fi, su);
    sa = longint'($signed(x));
    sb = longint'($signed(y));
    if (fi) begin
      sp = sa * sb;
      q = sp >>> 24;
      rem = sp[23:0];
      if (rt) begin
        if (rem > 24'h800000) q = q + 1;
        else if (rem == 24'h800000) q = q + (q & 1);
      end
      return {1'b0, q};
    end
    if (su) begin
      sp = sa * sb;
      lim = 64'sd1 <<< 39;
      v = (sp >= lim) || (sp < -lim);
      if (v && omc) sp = (sp < 0) ? ~(64'sd1 <<< 50) : (64'sd1 <<< 50);
      if (sc == 2'd1) sp = sp <<< 1;
      else if (sc == 2'd3) sp = sp >>> 1;
      return {v, sp};
    end
    up = {32'h0, x} * {32'h0, y};
    v = (up >> 40) != 0;
    if (v) up = omc ? (64'd1 << 50) : (up & ((64'd1 << 40) - 1));
    if (sc == 2'd1) up = up << 1;
    else if (sc == 2'd3) up = up >> 1;
    return {v, up};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic lng,
                       input logic ah, input logic bh, input logic [1:0] sc,
                       input logic [7:0] st, input string tag);
    logic [64:0] r;
    exp_t e;
    @(negedge clk);
    opA = a; opB = b; isLong = lng; aUpper = ah; bUpper = bh;
    scale = sc; macStatus = st; inValid = 1'b1;
    r = model(a, b, lng, ah, bh, sc, st);
    e.p = r[63:0]; e.v = r[64]; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = $urandom; opB = $urandom;
      scale = 2'($urandom); macStatus = 8'($urandom);
      isLong = 1'($urandom);
    end
  endtask

  always @(posedge clk) sampledValid <= inValid & rstN;

  // Compared on every falling edge
  always @(negedge clk) begin
    exp_t e;
    if (!rstN) begin
      compared++;
      if (outValid !== 1'b0 || product !== 64'h0 || prodOvf !== 1'b0) begin
        mismatched++;
        $display("FAIL R2: valid=%0b prod=%h v=%0b, expected valid=0 prod=0 v=0",
                 outValid, product, prodOvf);
      end
    end else if (sampledValid && expQ.size() > 0) begin
      e = expQ.pop_front();
      compared++;
      if (outValid !== 1'b1 || product !== e.p || prodOvf !== e.v) begin
        mismatched++;
        $display("FAIL %s: valid=%0b prod=%h v=%0b, expected valid=1 prod=%h v=%0b",
                 e.tag, outValid, product, prodOvf, e.p, e.v);
      end
      lastProd = product;
      lastOvf  = prodOvf;
    end else begin
      compared++;
      if (outValid !== 1'b0 || product !== lastProd || prodOvf !== lastOvf) begin
        mismatched++;
        $display("FAIL R1: valid=%0b prod=%h v=%0b, expected valid=0 prod=%h v=%0b",
                 outValid, product, prodOvf, lastProd, lastOvf);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R3: half extraction per mode
    apply(32'h8001_7FFF, 32'h0003_FFFE, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, "R3 uns word");
    apply(32'h8001_7FFF, 32'h0003_FFFE, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, "R3 uns word lo/hi");
    apply(32'h1234_FFFE, 32'h0005_0000, 1'b0, 1'b0, 1'b1, 2'd0, ST_SU, "R3 sgn word");
    apply(32'hC000_0000, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 2'd0, ST_FI, "R3 frac word");
    apply(32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU, "R3 long");
    // R4 signed without substitution
    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU, "R4 minus one");
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU, "R4 overflow");
    apply(32'h0000_8000, 32'h0100_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU, "R4 2^39 edge");
    apply(32'hFFFF_8000, 32'h0100_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU, "R4 -2^39 edge");
    // R5 substitution
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU | ST_OMC, "R5 positive");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU | ST_OMC, "R5 negative");
    apply(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU | ST_OMC, "R5 min squared");
    // R6 unsigned
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R6 truncate");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, ST_OMC, "R6 force");
    apply(32'h0001_0000, 32'h0100_0000, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R6 at 2^40");
    apply(32'h000F_FFFF, 32'h0010_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_OMC, "R6 below 2^40");
    // R7 fractional
    apply(32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI, "R7 negative");
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_OMC, "R7 no flag");
    // R8 rounding
    apply(32'h0080_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_RT, "R8 tie even");
    apply(32'h0080_0000, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_RT, "R8 tie odd");
    apply(32'h0080_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_RT, "R8 above half");
    apply(32'h007F_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_RT, "R8 below half");
    apply(32'hFF80_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_RT, "R8 negative tie");
    apply(32'h0000_0003, 32'h0000_0005, 1'b1, 1'b0, 1'b0, 2'd0, ST_SU | ST_RT, "R8 ignored int");
    // R9 scaling
    apply(32'hFFFF_FFFD, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 2'd1, ST_SU, "R9 sgn up");
    apply(32'hFFFF_FFFD, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 2'd3, ST_SU, "R9 sgn down");
    apply(32'hFFFF_FFFD, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, "R9 uns down");
    apply(32'hFFFF_FFFD, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 2'd2, ST_SU, "R9 scale two");
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd1, ST_SU | ST_OMC, "R9 force up");
    apply(32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'd1, ST_FI, "R9 frac ignores");
    // R10 precedence and unrelated bits
    apply(32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'd0, ST_FI | ST_SU | 8'h0F, "R10 frac wins");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 8'h0F, "R10 low bits");
    // R1 idle with changing inputs, then back-to-back
    idle(4);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) ra = 32'h8000_0000;
      if (i % 11 == 0) rb = 32'hFFFF_FFFF;
      apply(ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            8'($urandom), "R1 random");
      if (i % 13 == 0) idle(1 + (i % 3));
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1: watchdog expired, got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule